// File: doc/BRIEF.md
# Stepped Soft Mute Ramp

This block fades a stereo PCM stream in and out in response to a play/mute level input. Each time a frame strobe arrives, both channel samples are multiplied by the current gain, and the gain then moves one step along a logarithmic ladder. Each step is 1 dB. Ladder position 0 is unity gain and position 103 is exact silence.

A fall of the play level drives the ladder toward silence. A rise drives it back toward unity. If the level changes while a ramp is still running, the ramp reverses from its present position.

The play level is resynchronised inside the block. The scaled samples leave through a register one clock after their strobe, together with a flag that marks silent frames.

Top module: `soft_mute_ramp`

## Requirements
- R1: While reset is held and on the first clock after it, `outLeft` and `outRight` are 0, `outValid` is 0 and `muted` is 1.
- R2: If `playLvl` is high when reset is released, the first frame strobed at least four clocks after release passes both samples at unity gain (ladder position 0), and `muted` is 0.
- R3: If `playLvl` is low when reset is released, frames start at ladder position 103: both outputs are 0 and `muted` is 1.
- R4: The coefficient at ladder position k, for k from 0 to 102, is round(32768 · 10^(−k/20)). The coefficient at position 103 is 0. Each output equals (sample · coefficient + 16384) shifted right arithmetically by 15 bits, saturated to 24-bit signed.
- R5: After `playLvl` falls, and once the fall has passed the two-flop synchroniser, successive frames use ladder positions 0, 1, 2, … 103. The 104th frame of the ramp is therefore silent.
- R6: After `playLvl` rises from full mute, successive frames use positions 103, 102, … 0. The 104th frame of the ramp is at unity gain.
- R7: If the level reverses mid-ramp, the next frame uses the position the ramp had reached and the ramp proceeds from there in the new direction. It does not restart from an end.
- R8: `outValid` pulses for exactly the clock after each `frameStb`. `muted` is 1 exactly for frames produced with the zero coefficient.
- R9: The ladder position changes only on a frame strobe, by one step at most. It stays at position 0 or 103 once the level's target is reached, however many clocks or frames pass.
- R10: An output sample never exceeds its input sample in magnitude and never has the opposite sign. At unity gain, the full-scale values −8388608 and 8388607 pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frameStb | input | 1 | One-clock strobe marking a new stereo sample pair |
| inLeft | input | 24 | Left sample, signed two's complement |
| inRight | input | 24 | Right sample, signed two's complement |
| playLvl | input | 1 | Asynchronous level: high plays, low mutes |
| outLeft | output | 24 | Scaled left sample |
| outRight | output | 24 | Scaled right sample |
| outValid | output | 1 | High the clock after a frame strobe |
| muted | output | 1 | High when the last frame was produced at zero gain |

## Verification
The bench builds the block with its default parameters: 24-bit samples and a 16-bit coefficient. With these values a full 104-frame ramp costs only a few hundred clocks, so every ladder position is compared frame by frame in both directions. The bench also covers a mid-ramp reversal, idle stretches between frames, and both reset polarities of the play level. Full-scale positive and negative samples at unity gain show whether rounding or saturation disturbs the extremes.

// File: rtl/smr_pkg.sv
package smr_pkg;
  // Number of ladder positions: 0 dB down to -102 dB, then silence.
  localparam int STEP_COUNT = 104;
  localparam int IDX_W = $clog2(STEP_COUNT);

  // Command from control to datapath: strobe plus ladder position to apply.
  typedef struct packed {
    logic             apply;
    logic [IDX_W-1:0] idx;
  } gainCmd_t;
endpackage

// File: rtl/smr_ctrl.sv
module smr_ctrl
  import smr_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     frameStb,
  input  logic     playLvl,
  output gainCmd_t cmd
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STEP_COUNT - 1);

  logic [1:0]       syncQ;
  logic [1:0]       primeCnt;
  logic             primed;
  logic [IDX_W-1:0] stepIdx;
  logic [IDX_W-1:0] targetIdx;

  assign targetIdx = syncQ[1] ? '0 : LAST_IDX;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ    <= '0;
      primeCnt <= '0;
      primed   <= 1'b0;
      stepIdx  <= LAST_IDX;
    end else begin
      syncQ <= {syncQ[0], playLvl};
      if (!primed) begin
        // Wait until the synchroniser holds the real pin level, then snap.
        if (primeCnt == 2'd2) begin
          primed  <= 1'b1;
          stepIdx <= targetIdx;
        end else begin
          primeCnt <= primeCnt + 2'd1;
        end
      end else if (frameStb && (stepIdx != targetIdx)) begin
        stepIdx <= (stepIdx < targetIdx) ? stepIdx + 1'b1 : stepIdx - 1'b1;
      end
    end
  end

  assign cmd.apply = frameStb;
  assign cmd.idx   = stepIdx;

  p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
    primed |=> (stepIdx == $past(stepIdx)) || (stepIdx == $past(stepIdx) + 1'b1)
               || (stepIdx == $past(stepIdx) - 1'b1));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (primed && !frameStb) |=> $stable(stepIdx));

  p_idx_range_r4: assert property (@(posedge clk) disable iff (rst)
    stepIdx <= LAST_IDX);
endmodule

// File: rtl/smr_datapath.sv
module smr_datapath
  import smr_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  gainCmd_t                 cmd,
  input  logic signed [DATA_W-1:0] inLeft,
  input  logic signed [DATA_W-1:0] inRight,
  output logic signed [DATA_W-1:0] outLeft,
  output logic signed [DATA_W-1:0] outRight,
  output logic                     outValid,
  output logic                     muted
);
  localparam int PROD_W = DATA_W + COEF_W + 1;
  localparam int HALF   = 1 << (COEF_W - 2);
  localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((64'sd1 <<< (DATA_W - 1)) - 64'sd1);
  localparam logic signed [PROD_W-1:0] SAT_LO = -SAT_HI - 1;

  // Unsigned Q1.(COEF_W-1) multiplier for ladder position k (unity = 2^(COEF_W-1)).
  function automatic int coefFor(int k);
    if (k >= STEP_COUNT - 1) return 0;
    return $rtoi((2.0 ** (COEF_W - 1)) * $pow(10.0, -k / 20.0) + 0.5);
  endfunction

  logic [COEF_W-1:0] coefRom [STEP_COUNT];
  logic [COEF_W-1:0] coefSel;

  for (genvar k = 0; k < STEP_COUNT; k++) begin : g_rom
    assign coefRom[k] = COEF_W'(coefFor(k));
  end

  assign coefSel = (cmd.idx < IDX_W'(STEP_COUNT)) ? coefRom[cmd.idx] : '0;

  for (genvar c = 0; c < 2; c++) begin : g_chan
    logic signed [DATA_W-1:0] src;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rounded;
    logic signed [DATA_W-1:0] scaled;

    assign src = (c == 0) ? inLeft : inRight;

    always_comb begin
      prod    = $signed(PROD_W'(src)) * $signed(PROD_W'({1'b0, coefSel}));
      rounded = (prod + $signed(PROD_W'(HALF))) >>> (COEF_W - 1);
      if (rounded > SAT_HI)      scaled = SAT_HI[DATA_W-1:0];
      else if (rounded < SAT_LO) scaled = SAT_LO[DATA_W-1:0];
      else                       scaled = rounded[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outLeft  <= '0;
      outRight <= '0;
      outValid <= 1'b0;
      muted    <= 1'b1;
    end else begin
      outValid <= cmd.apply;
      if (cmd.apply) begin
        outLeft  <= g_chan[0].scaled;
        outRight <= g_chan[1].scaled;
        muted    <= (coefSel == '0);
      end
    end
  end

  p_unity_pass_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd.apply && cmd.idx == '0) |=> (outLeft == $past(inLeft)) && (outRight == $past(inRight)));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    cmd.apply |=> ($past(inLeft) >= 0) ? (outLeft >= 0 && outLeft <= $past(inLeft))
                                       : (outLeft <= 0 && outLeft >= $past(inLeft)));

  p_muted_silent_r8: assert property (@(posedge clk) disable iff (rst)
    muted |-> (outLeft == '0) && (outRight == '0));

  p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
    cmd.apply |=> outValid);
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
  import smr_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int COEF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frameStb,
  input  logic signed [DATA_W-1:0] inLeft,
  input  logic signed [DATA_W-1:0] inRight,
  input  logic                     playLvl,
  output logic signed [DATA_W-1:0] outLeft,
  output logic signed [DATA_W-1:0] outRight,
  output logic                     outValid,
  output logic                     muted
);
  gainCmd_t cmd;

  smr_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .frameStb (frameStb),
    .playLvl  (playLvl),
    .cmd      (cmd)
  );

  smr_datapath #(.DATA_W(DATA_W), .COEF_W(COEF_W)) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .inLeft   (inLeft),
    .inRight  (inRight),
    .outLeft  (outLeft),
    .outRight (outRight),
    .outValid (outValid),
    .muted    (muted)
  );
endmodule

// File: tb/test_soft_mute_ramp.sv
module test_soft_mute_ramp;
  localparam int LAST = 103;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frameStb = 1'b0;
  logic signed [23:0] inLeft = '0;
  logic signed [23:0] inRight = '0;
  logic playLvl = 1'b1;
  logic signed [23:0] outLeft, outRight;
  logic outValid, muted;

  int checks = 0;
  int errors = 0;
  int modelIdx = 0;
  bit modelPlay = 1'b1;
  bit done = 1'b0;

  always #10 clk = ~clk;

  soft_mute_ramp i_soft_mute_ramp (
    .clk(clk), .rst(rst), .frameStb(frameStb), .inLeft(inLeft), .inRight(inRight),
    .playLvl(playLvl), .outLeft(outLeft), .outRight(outRight),
    .outValid(outValid), .muted(muted)
  );

  // {play level, left sample, right sample}
  localparam logic [48:0] VECS [10] = '{
    {1'b1,  24'sd123456,   -24'sd654321},
    {1'b1,  24'sd8388607,  -24'sd8388608},
    {1'b1,  24'sd0,         24'sd1},
    {1'b0,  24'sd1000000,  -24'sd1000000},
    {1'b0,  24'sd4000000,  -24'sd3},
    {1'b0, -24'sd8388608,   24'sd8388607},
    {1'b0,  24'sd777,      -24'sd777},
    {1'b1,  24'sd5000000,   24'sd2500000},
    {1'b1, -24'sd1,         24'sd1},
    {1'b1,  24'sd65536,    -24'sd65536}
  };

  function automatic int coefM(int k);
    if (k >= LAST) return 0;
    return $rtoi(32768.0 * (10.0 ** (-k / 20.0)) + 0.5);
  endfunction

  function automatic int scaleM(int s, int c);
    longint p;
    p = longint'(s) * longint'(c) + 64'sd16384;
    return int'(p >>> 15);
  endfunction

  task automatic checkEq(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setPin(bit lvl);
    @(negedge clk);
    playLvl = lvl;
    modelPlay = lvl;
    repeat (4) @(negedge clk);
  endtask

  task automatic doFrame(string req, int l, int r);
    int c, expL, expR;
    c = coefM(modelIdx);
    expL = scaleM(l, c);
    expR = scaleM(r, c);
    @(negedge clk);
    inLeft = 24'(l);
    inRight = 24'(r);
    frameStb = 1'b1;
    @(negedge clk);
    frameStb = 1'b0;
    checkEq(req, "outLeft", outLeft, expL);
    checkEq(req, "outRight", outRight, expR);
    checkEq(req, "outValid", outValid, 1);
    checkEq(req, "muted", muted, (c == 0) ? 1 : 0);
    @(negedge clk);
    checkEq("R8", "outValid drop", outValid, 0);
    if (modelPlay && modelIdx > 0) modelIdx--;
    else if (!modelPlay && modelIdx < LAST) modelIdx++;
  endtask

  task automatic doReset(bit lvl);
    @(negedge clk);
    rst = 1'b1;
    playLvl = lvl;
    modelPlay = lvl;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkEq("R1", "outLeft", outLeft, 0);
    checkEq("R1", "outRight", outRight, 0);
    checkEq("R1", "outValid", outValid, 0);
    checkEq("R1", "muted", muted, 1);
    repeat (4) @(negedge clk);
    modelIdx = lvl ? 0 : LAST;
  endtask

  initial begin
    // Reset state and start at unity.
    repeat (2) @(negedge clk);
    checkEq("R1", "muted in reset", muted, 1);
    doReset(1'b1);
    doFrame("R2", 4242, -4242);
    checkEq("R2", "unity left", outLeft, 4242);

    // Vector table walk.
    for (int v = 0; v < 10; v++) begin
      if (VECS[v][48] != modelPlay) setPin(VECS[v][48]);
      doFrame("R4", int'($signed(VECS[v][47:24])), int'($signed(VECS[v][23:0])));
    end

    // Return to unity, then full ramp down.
    setPin(1'b1);
    while (modelIdx != 0) doFrame("R6", 100000, -100000);
    setPin(1'b0);
    for (int n = 0; n < 104; n++) doFrame("R5", 8388607, -8388608);
    checkEq("R5", "silent after 104 frames", outLeft, 0);
    doFrame("R9", 3000000, -3000000);
    repeat (20) @(negedge clk);
    doFrame("R9", 3000000, -3000000);
    checkEq("R9", "stays muted", muted, 1);

    // Full ramp up.
    setPin(1'b1);
    for (int n = 0; n < 104; n++) doFrame("R6", 2000000, -2000000);
    checkEq("R6", "unity after 104 frames", outLeft, 2000000);
    doFrame("R10", 8388607, -8388608);
    checkEq("R10", "full scale pos", outLeft, 8388607);
    checkEq("R10", "full scale neg", outRight, -8388608);

    // Reversal mid-ramp.
    setPin(1'b0);
    for (int n = 0; n < 10; n++) doFrame("R5", 1000000, 1000000);
    setPin(1'b1);
    checkEq("R7", "model position", modelIdx, 10);
    doFrame("R7", 1000000, 1000000);
    checkEq("R7", "resumes at step 10", outLeft, scaleM(1000000, coefM(10)));
    while (modelIdx != 0) doFrame("R7", 1000000, 1000000);

    // Reset with the level low.
    doReset(1'b0);
    doFrame("R3", 5000000, -5000000);
    checkEq("R3", "muted after low reset", muted, 1);
    checkEq("R3", "silent left", outLeft, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule